// File: doc/BRIEF.md
# Bidirectional Reflection Line Emulator

This block is a clocked, discrete model of a lossy transmission line. The line is cut into a fixed number of segments. One register chain carries the incident wave from the source end toward the load. A second chain carries returning waves back toward the source. Every clock is one simulation step, and every wave moves one segment per step. A one-cycle strobe at the source injects a pulse of fixed amplitude. Each hop between neighbouring segments scales the wave by a programmable loss factor.

At the far end, the load is chosen at run time as an open circuit or a short circuit. An open returns the arriving sample unchanged. A short returns its negation.

One interior node can be placed at any segment except the last. It carries a fractional reflection coefficient. At that node part of the forward wave turns back toward the source, and the rest goes on toward the load. The source is matched, so nothing is reflected there. The output is the saturated sum of the two waves at segment 0, updated every step. A trace of this output over time gives the impedance profile of the emulated line: echo delay gives position, and echo sign gives the kind of fault.

Top module: `tdr_line_emu`

## Requirements
- R1: The reset (`rst_n` low, synchronous) clears both chains. In the first step after release, `src_v_o` is 0. A pulse that was in flight when reset came never returns.
- R2: A launch strobe sampled at a clock edge makes `src_v_o` equal `PULSE_AMP` (default +127) right after that edge. Segment 0 of the forward chain holds the pulse for exactly one step.
- R3: Every hop between adjacent segments, in either direction, multiplies the wave by `atten_i`/256. `atten_i` is an unsigned Q0.8 value. Each product is rounded toward zero and clipped to -127..+127.
- R4: With `load_short_i` = 0 (open), the sample at the last forward segment is copied unchanged into the last reverse segment one step later. The echo of a launch reaches `src_v_o` 2·NSEG−1 steps after the launch edge.
- R5: With `load_short_i` = 1 (short), the last reverse segment receives the negated sample. The echo therefore has the same magnitude as the open-load echo and the opposite sign.
- R6: When `mm_pos_i` = m ≤ NSEG−2, the forward sample V at segment m also sends round(V·`mm_rho_i`/256) into reverse segment m one step later. This partial echo reaches `src_v_o` 2m+1 steps after launch.
- R7: At the node, the part passed on toward the load is round(V·(256−`mm_rho_i`)/256). That part is then attenuated on the following hop. A coefficient of 0 passes V unchanged.
- R8: A value of `mm_pos_i` of NSEG−1 or more disables the interior node. No partial echo appears, and the load echo is the same as with a zero coefficient.
- R9: The source is matched. Without a launch, segment 0 of the forward chain stays 0, so an echo that reaches the source is not sent back down the line and `src_v_o` returns to 0.
- R10: A launch made while earlier waves are in flight is still injected, and the waves superpose. `src_v_o` is the sum at segment 0, clipped to -127..+127 and never -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation step clock |
| rst_n | input | 1 | Synchronous reset, active low |
| launch_i | input | 1 | One-cycle strobe that injects a pulse at the source |
| load_short_i | input | 1 | Far-end termination: 0 open, 1 short |
| mm_pos_i | input | $clog2(NSEG) | Segment index of the interior mismatch node |
| mm_rho_i | input | 8 | Mismatch reflection coefficient, unsigned Q0.8 |
| atten_i | input | 8 | Per-hop loss factor, unsigned Q0.8 |
| src_v_o | output | 8 | Signed, saturated source-node voltage |

## Verification
The bench places the interior node at segment 0, where its echo comes back in the very next step. It also places the node at a middle segment and at the disabled last index. A node that decoded the disabled position would then create a spurious early echo, and an off-by-one in the hop count would move the echo by two steps.

Short-load runs with loss check that negative products round toward zero. Rounding toward minus infinity would make the short echo one or more LSBs larger in magnitude than the open echo.

A second launch is timed to land on the first echo. A sum that wraps instead of clipping would show a negative spike there. A reflecting source would make the trace ring after the echo.

A reset during a flight checks that no stale echo survives.

// File: rtl/tdr_pkg.sv
// Shared sample type and saturation helper for the reflection line emulator.
// Assumes signed 8-bit wave samples and Q0.8 unsigned coefficients.
package tdr_pkg;
    localparam int SAMP_W  = 8;
    localparam int FRAC_W  = 8;
    localparam int SAMP_MAX = 127;

    typedef logic signed [SAMP_W-1:0] samp_t;

    // Clip a widened signed value into the symmetric range -127..+127.
    function automatic samp_t clip_samp(input logic signed [10:0] x);
        if (x > 11'sd127)
            return samp_t'(SAMP_MAX);
        else if (x < -11'sd127)
            return samp_t'(-SAMP_MAX);
        else
            return x[SAMP_W-1:0];
    endfunction
endpackage

// File: rtl/tdr_scale.sv
// Multiplies a signed sample by an unsigned coefficient in units of 1/256.
// Rounds toward zero, then saturates. Coefficient range is 0..256 (9 bits).
module tdr_scale
    import tdr_pkg::*;
(
    input  samp_t              v_i,
    input  logic [FRAC_W:0]    coef_i,
    output samp_t              v_o
);
    logic signed [17:0] prod;
    logic        [17:0] mag;
    logic        [9:0]  quo;
    logic signed [10:0] res;

    // Sign-magnitude rounding toward zero of the scaled product.
    always_comb begin
        prod = v_i * $signed({1'b0, coef_i});
        mag  = prod[17] ? 18'(-prod) : 18'(prod);
        quo  = mag[17:8];
        res  = prod[17] ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
        v_o  = clip_samp(res);
    end
endmodule

// File: rtl/tdr_sat_add.sv
// Saturating adder of two signed samples, result clipped to -127..+127.
module tdr_sat_add
    import tdr_pkg::*;
(
    input  samp_t a_i,
    input  samp_t b_i,
    output samp_t sum_o
);
    // Widen, add, clip.
    always_comb sum_o = clip_samp(11'(a_i) + 11'(b_i));
endmodule

// File: rtl/tdr_load_refl.sv
// Far-end termination: an open returns the sample, a short returns its negation.
// Assumes the input is already within -127..+127.
module tdr_load_refl
    import tdr_pkg::*;
(
    input  samp_t v_i,
    input  logic  short_i,
    output samp_t v_o
);
    // Select the reflected sample from the termination type.
    always_comb v_o = short_i ? clip_samp(-(11'(v_i))) : v_i;
endmodule

// File: rtl/tdr_line_emu.sv
// Two opposing chains of signed samples model a lossy line of NSEG segments.
// The forward chain moves toward the load and the reverse chain toward the
// source. The load end reflects as open or short. One interior node at
// mm_pos_i splits the forward wave by mm_rho_i. The source is matched.
// Assumes NSEG >= 3.
module tdr_line_emu
    import tdr_pkg::*;
#(
    parameter int NSEG      = 16,
    parameter int PULSE_AMP = 127,
    localparam int PW       = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              load_short_i,
    input  logic [PW-1:0]     mm_pos_i,
    input  logic [FRAC_W-1:0] mm_rho_i,
    input  logic [FRAC_W-1:0] atten_i,
    output samp_t             src_v_o
);
    localparam int LAST = NSEG - 1;

    samp_t fwd    [NSEG];
    samp_t rev    [NSEG];
    samp_t fwd_nx [NSEG];
    samp_t rev_nx [NSEG];
    samp_t hop_in [NSEG-1];
    samp_t rev_at [NSEG-1];
    samp_t inj    [NSEG-1];

    samp_t          mm_in, refl_v, trans_v;
    logic           mm_act;
    logic [FRAC_W:0] att_c, rho_c, trans_c;

    assign att_c   = {1'b0, atten_i};
    assign rho_c   = {1'b0, mm_rho_i};
    assign trans_c = (FRAC_W+1)'(256) - rho_c;
    assign mm_act  = (mm_pos_i <= PW'(NSEG - 2));

    // Pick the forward sample sitting at the mismatch node.
    always_comb begin
        mm_in = '0;
        for (int i = 0; i < NSEG; i++)
            if (mm_pos_i == PW'(i)) mm_in = fwd[i];
    end

    tdr_scale u_refl  (.v_i(mm_in), .coef_i(rho_c),   .v_o(refl_v));
    tdr_scale u_trans (.v_i(mm_in), .coef_i(trans_c), .v_o(trans_v));

    // Matched source: only a launch enters segment 0.
    assign fwd_nx[0] = launch_i ? samp_t'(PULSE_AMP) : samp_t'(0);

    genvar g;
    generate
        for (g = 0; g < NSEG - 1; g++) begin : g_hop
            // Forward hop g -> g+1, passing the transmitted part at the node.
            assign hop_in[g] = (mm_act && mm_pos_i == PW'(g)) ? trans_v : fwd[g];
            tdr_scale u_fatt (.v_i(hop_in[g]), .coef_i(att_c), .v_o(fwd_nx[g+1]));

            // Reverse hop g+1 -> g, adding the partial echo at the node.
            tdr_scale u_ratt (.v_i(rev[g+1]), .coef_i(att_c), .v_o(rev_at[g]));
            assign inj[g] = (mm_act && mm_pos_i == PW'(g)) ? refl_v : samp_t'(0);
            tdr_sat_add u_radd (.a_i(rev_at[g]), .b_i(inj[g]), .sum_o(rev_nx[g]));
        end
    endgenerate

    tdr_load_refl u_load (.v_i(fwd[LAST]), .short_i(load_short_i), .v_o(rev_nx[LAST]));

    // Advance both chains one segment per step; reset empties the line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSEG; i++) begin
            if (!rst_n) begin
                fwd[i] <= '0;
                rev[i] <= '0;
            end else begin
                fwd[i] <= fwd_nx[i];
                rev[i] <= rev_nx[i];
            end
        end
    end

    tdr_sat_add u_src (.a_i(fwd[0]), .b_i(rev[0]), .sum_o(src_v_o));
endmodule

// File: rtl/tdr_line_chk.sv
// Property checker for the reflection line emulator, bound to every instance.
// Watches the source head, the load boundary and the output range.
module tdr_line_chk
    import tdr_pkg::*;
#(
    parameter int PULSE_AMP = 127
) (
    input logic  clk,
    input logic  rst_n,
    input logic  launch_i,
    input logic  load_short_i,
    input samp_t fwd_head,
    input samp_t fwd_tail,
    input samp_t rev_tail,
    input samp_t src_v_o
);
    AST_RESET_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> src_v_o == 0);                                  // R1
    AST_LAUNCH_HEAD:  assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> fwd_head == samp_t'(PULSE_AMP));                    // R2
    AST_OPEN_COPY:    assert property (@(posedge clk) disable iff (!rst_n)
        !load_short_i |=> rev_tail == $past(fwd_tail));                  // R4
    AST_SHORT_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
        load_short_i |=> rev_tail == -$past(fwd_tail));                  // R5
    AST_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_i |=> fwd_head == 0);                                    // R9
    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        src_v_o != -8'sd128);                                            // R10
endmodule

bind tdr_line_emu tdr_line_chk #(.PULSE_AMP(PULSE_AMP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch_i),
    .load_short_i (load_short_i),
    .fwd_head     (fwd[0]),
    .fwd_tail     (fwd[NSEG-1]),
    .rev_tail     (rev[NSEG-1]),
    .src_v_o      (src_v_o)
);

// File: tb/sim_tdr_line_emu.sv
// Scoreboard bench: the driver queues the expected source trace per run,
// and the monitor pops one item per step and compares it with the output.
module sim_tdr_line_emu;
    localparam int N   = 16;
    localparam int AMP = 127;
    localparam int PW  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              launch = 1'b0;
    logic              short_ld = 1'b0;
    logic [PW-1:0]     pos = '0;
    logic [7:0]        rho = '0;
    logic [7:0]        att = 8'd255;
    logic signed [7:0] src;

    always #4 clk = ~clk;

    tdr_line_emu #(.NSEG(N), .PULSE_AMP(AMP)) u0 (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .load_short_i(short_ld),
        .mm_pos_i(pos), .mm_rho_i(rho), .atten_i(att), .src_v_o(src)
    );

    typedef struct { int val; string req; } exp_t;
    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    function automatic int clip(int v);
        if (v > 127)  return 127;
        if (v < -127) return -127;
        return v;
    endfunction

    // Integer division truncates toward zero, matching the rounding rule.
    function automatic int hops(int v, int a, int n);
        int x = v;
        for (int i = 0; i < n; i++) x = clip((x * a) / 256);
        return x;
    endfunction

    // Source trace of one isolated pulse, k steps after its launch edge.
    function automatic int resp(int k, bit sh, int m, int r, int a);
        int t, s;
        s = 0;
        if (k == 0) s += AMP;
        if (m <= N - 2) begin
            t = hops(AMP, a, m);
            if (k == 2 * m + 1) s += hops(clip((t * r) / 256), a, m);
            t = hops(clip((t * (256 - r)) / 256), a, N - 1 - m);
        end else begin
            t = hops(AMP, a, N - 1);
        end
        if (k == 2 * N - 1) s += hops(sh ? -t : t, a, N - 1);
        return s;
    endfunction

    task automatic check(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: src_v_o actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: one comparison per step, just after the active edge.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(int'(src), e.val, e.req);
        end
    end

    // Driver: set up the line, queue the expected trace, fire the launches.
    task automatic run_case(bit sh, int m, int r, int a, int off2,
                            string tag_echo, string tag_refl);
        int len;
        @(negedge clk);
        short_ld = sh; pos = PW'(m); rho = 8'(r); att = 8'(a);
        @(negedge clk);
        len = 4 * N + (off2 > 0 ? off2 : 0);
        for (int j = 0; j < len; j++) begin
            exp_t e;
            int   v;
            v = resp(j, sh, m, r, a);
            if (off2 > 0 && j >= off2) v += resp(j - off2, sh, m, r, a);
            e.val = clip(v);
            if (j == 0)
                e.req = "R2";
            else if (j == 2 * N - 1 || (off2 > 0 && j - off2 == 2 * N - 1))
                e.req = tag_echo;
            else if (m <= N - 2 && (j == 2 * m + 1 || (off2 > 0 && j - off2 == 2 * m + 1)))
                e.req = tag_refl;
            else if (off2 > 0 && j == off2)
                e.req = "R10";
            else
                e.req = "R9";
            sb.push_back(e);
        end
        for (int j = 0; j < len; j++) begin
            launch = (j == 0) || (j == off2);
            @(negedge clk);
        end
        launch = 1'b0;
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(src), 0, "R1");

        // Open load with light loss; node parked at the disabled index (R8).
        run_case(1'b0, N - 1, 128, 255, -1, "R4_R8", "R8");
        // Short load, same loss: echo negated, same magnitude.
        run_case(1'b1, N - 1, 128, 255, -1, "R5", "R5");
        // Heavy loss on an open line.
        run_case(1'b0, N - 1, 0, 200, -1, "R3", "R3");
        // Zero coefficient at a middle node passes the wave unchanged.
        run_case(1'b0, 7, 0, 240, -1, "R7", "R7");
        // Middle node with a quarter reflection.
        run_case(1'b0, 5, 64, 255, -1, "R7", "R6");
        // Node at segment 0 with a short load and loss on negative values.
        run_case(1'b1, 0, 200, 230, -1, "R5_R7", "R6");
        // Second launch while the first is still travelling.
        run_case(1'b0, N - 1, 0, 255, 3, "R10", "R10");
        // Second launch lands on the first echo: the sum must clip.
        run_case(1'b0, N - 1, 0, 255, 2 * N - 1, "R10", "R10");

        // Reset during a flight: no stale echo afterwards.
        @(negedge clk);
        short_ld = 1'b0; pos = PW'(N - 1); att = 8'd255;
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 4 * N; j++) begin
            @(negedge clk);
            check(int'(src), 0, "R1");
        end

        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..: actual=running expected=finished");
        finish_run();
    end
endmodule